// File: doc/BRIEF.md
# Configurable Command/Address Registered Buffer with Cascadable Parity

This block sits between a memory controller and the DRAM devices on a module, registering command and address lines on each rising clock edge. A two-bit configuration input picks the topology at run time. In the wide topology 25 input bits are registered and driven one-to-one. In the narrow topology 14 input bits are registered and each is driven onto two identical output banks. The narrow topology also marks the device as the leading or the trailing member of a cascaded pair.

Alongside the data the block takes a parity bit and checks even parity over its checked data bits. It publishes a partial-parity result so that a second device can fold it into its own check, which lets a parity group span two devices. An active-low error flag reports a failed word one clock after the word was registered. Chip-select inputs freeze the checked data outputs and the parity state while the device is deselected. The control bits of the word still update during that time.

The error path is a two-state machine. CHK_IDLE means no selected word is held. CHK_ARMED means the registers hold a word captured while selected. On every edge the machine goes to CHK_ARMED if the device is selected (transitions IDLE→ARMED, ARMED→ARMED) and to CHK_IDLE if it is deselected (ARMED→IDLE, IDLE→IDLE). Reset forces CHK_IDLE. The error flag register is loaded from the parity result only while the machine is in CHK_ARMED.

Top module: `regbuf_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears `q_a` and `q_b` to zero, drives `err_n` high, and clears the parity register. The machine returns to CHK_IDLE.
- R2: With `cfg`=2'b00 (wide) and the device selected, `q_a` shows the `d` value captured at the previous rising edge, and `q_b` is all zero.
- R3: With `cfg`=2'b01 or 2'b10 (narrow), `q_a[13:0]` and `q_b[13:0]` both show the captured `d[13:0]`, and `q_a[24:14]` is zero.
- R4: `cfg`=2'b11 behaves exactly like `cfg`=2'b00.
- R5: The device is deselected when both `cs_n` bits are high at an edge. On such an edge the non-control data bits and the registered parity bit keep their values. The control bits still capture; these are `d[24:22]` in wide mode and `d[13:11]` in narrow mode.
- R6: Parity covers only the checked bits: `d[21:0]` in wide mode and `d[10:0]` in narrow mode. The control bits never affect `ppar_out` or `err_n`.
- R7: In wide mode, `err_n` goes low in the cycle after the edge that follows a selected capture whose checked bits plus `par_in` hold an odd number of ones. It stays low for one cycle only, unless the next word also fails.
- R8: In wide mode and leading mode, `ppar_out` is the XOR of the registered checked bits and the registered `par_in`. It is valid in the same cycle as the registered data.
- R9: In trailing mode (`cfg`=2'b10), `ppar_in` replaces the registered `par_in`. `ppar_out` is the XOR of the registered checked bits and `ppar_in`, and `err_n` is the inverse of that value one cycle later, subject to the timing of R7.
- R10: In leading mode (`cfg`=2'b01), `err_n` stays high whatever the parity.
- R11: If the device was deselected at the previous edge, `err_n` is high after the next edge, even when the held word has bad parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg | input | 2 | Topology: 00/11 wide, 01 narrow leading, 10 narrow trailing |
| cs_n | input | 2 | Active-low chip selects; deselected when both high |
| d | input | 25 | Command/address data; top bits of the active width are control bits |
| par_in | input | 1 | Even-parity bit from the controller |
| ppar_in | input | 1 | Partial parity from the leading device of a pair |
| q_a | output | 25 | Registered outputs, bank A |
| q_b | output | 14 | Registered outputs, bank B (narrow copy) |
| ppar_out | output | 1 | Partial parity of the registered word |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The interesting collision is a deselect that lands one edge after a selected word with bad parity. On the same edge, the error flag must report the old word while the chip-select gating freezes the data and advances the machine to CHK_IDLE. The bench provokes this by alternating `cs_n`=2'b11 with selected cycles while feeding random words with random good or bad parity, in both wide and narrow modes. On every clock it compares all four outputs against a behavioural model that tracks the held word, the armed flag and the flag timing. Control bits change during the deselected cycles, so the bench also judges that they update while the checked bits and the parity result hold.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

    typedef enum logic [1:0] {
        MODE_WIDE      = 2'b00,
        MODE_PAIR_LEAD = 2'b01,
        MODE_PAIR_TAIL = 2'b10
    } buf_mode_e;

    typedef enum logic {
        CHK_IDLE  = 1'b0,
        CHK_ARMED = 1'b1
    } chk_state_e;

    function automatic buf_mode_e decode_mode(input logic [1:0] cfg);
        unique case (cfg)
            2'b01:   return MODE_PAIR_LEAD;
            2'b10:   return MODE_PAIR_TAIL;
            default: return MODE_WIDE;
        endcase
    endfunction

    function automatic logic mode_is_narrow(input buf_mode_e m);
        return (m == MODE_PAIR_LEAD) || (m == MODE_PAIR_TAIL);
    endfunction

endpackage

// File: rtl/regbuf_capture.sv
module regbuf_capture
    import regbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14,
    parameter int CTRL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  buf_mode_e         mode,
    input  logic              sel,
    input  logic [WIDE_W-1:0] d,
    input  logic              par_in,
    output logic [WIDE_W-1:0] data_q,
    output logic              par_q
);

    logic narrow;
    assign narrow = mode_is_narrow(mode);

    for (genvar i = 0; i < WIDE_W; i++) begin : g_bit
        localparam bit WIDE_CTRL   = (i >= WIDE_W - CTRL_W);
        localparam bit NARROW_CTRL = (i >= NARROW_W - CTRL_W) && (i < NARROW_W);
        logic is_ctrl;
        assign is_ctrl = narrow ? NARROW_CTRL : WIDE_CTRL;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[i] <= 1'b0;
            end else if (sel || is_ctrl) begin
                data_q[i] <= d[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= 1'b0;
        end else if (sel) begin
            par_q <= par_in;
        end
    end

    // R5: a deselected edge leaves the parity register untouched
    a_r5_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(par_q));

endmodule

// File: rtl/regbuf_parity.sv
module regbuf_parity
    import regbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14,
    parameter int CTRL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  buf_mode_e         mode,
    input  logic              sel,
    input  logic [WIDE_W-1:0] data_q,
    input  logic              par_q,
    input  logic              ppar_in,
    output logic              ppar_out,
    output logic              err_n
);

    logic              narrow;
    logic [WIDE_W-1:0] chk_mask;
    logic              own_x;
    logic              fold_bit;
    chk_state_e        state_q;
    chk_state_e        state_d;

    assign narrow = mode_is_narrow(mode);

    for (genvar i = 0; i < WIDE_W; i++) begin : g_mask
        localparam bit WIDE_CHK   = (i < WIDE_W - CTRL_W);
        localparam bit NARROW_CHK = (i < NARROW_W - CTRL_W);
        assign chk_mask[i] = narrow ? NARROW_CHK : WIDE_CHK;
    end

    assign own_x    = ^(data_q & chk_mask);
    assign fold_bit = (mode == MODE_PAIR_TAIL) ? ppar_in : par_q;
    assign ppar_out = own_x ^ fold_bit;

    always_comb begin
        unique case (state_q)
            CHK_IDLE:  state_d = sel ? CHK_ARMED : CHK_IDLE;
            CHK_ARMED: state_d = sel ? CHK_ARMED : CHK_IDLE;
            default:   state_d = CHK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CHK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_n <= 1'b1;
        end else begin
            unique case (state_q)
                CHK_IDLE:  err_n <= 1'b1;
                CHK_ARMED: err_n <= (mode == MODE_PAIR_LEAD) ? 1'b1 : ~ppar_out;
                default:   err_n <= 1'b1;
            endcase
        end
    end

    // R7: the flag only drops after a cycle whose parity result was odd
    a_r7_err_from_odd: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> $past(ppar_out));

    // R10: a leading device never reports
    a_r10_lead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_PAIR_LEAD) |-> err_n);

    // R11: a deselected edge is followed by a quiet flag
    a_r11_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sel) |=> err_n);

endmodule

// File: rtl/regbuf_fanout.sv
module regbuf_fanout
    import regbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input  buf_mode_e           mode,
    input  logic [WIDE_W-1:0]   data_q,
    output logic [WIDE_W-1:0]   q_a,
    output logic [NARROW_W-1:0] q_b
);

    logic narrow;
    assign narrow = mode_is_narrow(mode);

    for (genvar i = 0; i < WIDE_W; i++) begin : g_bank_a
        if (i < NARROW_W) begin : g_shared
            assign q_a[i] = data_q[i];
        end else begin : g_wide_only
            assign q_a[i] = narrow ? 1'b0 : data_q[i];
        end
    end

    for (genvar j = 0; j < NARROW_W; j++) begin : g_bank_b
        assign q_b[j] = narrow ? data_q[j] : 1'b0;
    end

endmodule

// File: rtl/regbuf_top.sv
module regbuf_top
    import regbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14,
    parameter int CTRL_W   = 3,
    parameter int CS_W     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg,
    input  logic [CS_W-1:0]     cs_n,
    input  logic [WIDE_W-1:0]   d,
    input  logic                par_in,
    input  logic                ppar_in,
    output logic [WIDE_W-1:0]   q_a,
    output logic [NARROW_W-1:0] q_b,
    output logic                ppar_out,
    output logic                err_n
);

    buf_mode_e         mode;
    logic              sel;
    logic [WIDE_W-1:0] data_q;
    logic              par_q;

    assign mode = decode_mode(cfg);
    assign sel  = ~&cs_n;

    regbuf_capture #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .CTRL_W(CTRL_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .sel    (sel),
        .d      (d),
        .par_in (par_in),
        .data_q (data_q),
        .par_q  (par_q)
    );

    regbuf_parity #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .CTRL_W(CTRL_W)) u_parity (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .sel      (sel),
        .data_q   (data_q),
        .par_q    (par_q),
        .ppar_in  (ppar_in),
        .ppar_out (ppar_out),
        .err_n    (err_n)
    );

    regbuf_fanout #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_fanout (
        .mode   (mode),
        .data_q (data_q),
        .q_a    (q_a),
        .q_b    (q_b)
    );

    // R1: a reset edge leaves cleared outputs and a quiet flag
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (err_n && (q_a == '0) && (q_b == '0)));

endmodule

// File: tb/tb_regbuf_top.sv
`timescale 1ns/1ps
module tb_regbuf_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg = 2'b00;
    logic [1:0]  cs_n = 2'b11;
    logic [24:0] d = '0;
    logic        par_in = 1'b0;
    logic        ppar_in = 1'b0;
    logic [24:0] q_a;
    logic [13:0] q_b;
    logic        ppar_out;
    logic        err_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    logic [24:0] m_data = '0;
    bit          m_par = 0;
    bit          m_armed = 0;
    bit          m_errn = 1;

    always #2 clk = ~clk;

    regbuf_top dut (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .cs_n(cs_n), .d(d),
        .par_in(par_in), .ppar_in(ppar_in), .q_a(q_a), .q_b(q_b),
        .ppar_out(ppar_out), .err_n(err_n)
    );

    function automatic bit is_narrow(input logic [1:0] c);
        return (c == 2'b01) || (c == 2'b10);
    endfunction

    function automatic int act_width(input logic [1:0] c);
        return is_narrow(c) ? 14 : 25;
    endfunction

    function automatic bit checked_xor(input logic [24:0] v, input logic [1:0] c);
        bit x = 0;
        for (int i = 0; i < act_width(c) - 3; i++) x ^= v[i];
        return x;
    endfunction

    function automatic bit exp_ppar();
        return checked_xor(m_data, cfg) ^ ((cfg == 2'b10) ? ppar_in : m_par);
    endfunction

    task automatic check(input bit ok, input string step, input string req,
                         input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL step=%s %s %s actual=%h expected=%h", step, req, what, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] c, input logic [1:0] cs, input logic [24:0] dv,
                        input bit p, input bit pp, input bit r, input string tag);
        logic [24:0] ea;
        logic [13:0] eb;
        bit nxt;
        bit s;
        int w;
        cfg = c; cs_n = cs; d = dv; par_in = p; ppar_in = pp; rst_n = r;
        @(posedge clk);
        if (!r) begin
            m_data = '0; m_par = 0; m_armed = 0; m_errn = 1;
        end else begin
            nxt = !(m_armed && (c != 2'b01) && exp_ppar());
            s = !(cs == 2'b11);
            w = act_width(c);
            for (int i = 0; i < 25; i++)
                if (s || (i >= w - 3 && i < w)) m_data[i] = dv[i];
            if (s) m_par = p;
            m_armed = s;
            m_errn = nxt;
        end
        @(negedge clk);
        ea = m_data;
        eb = '0;
        if (is_narrow(c)) begin
            ea[24:14] = '0;
            eb = m_data[13:0];
        end
        check(q_a === ea, tag, is_narrow(c) ? "R3" : "R2", "q_a", 32'(q_a), 32'(ea));
        check(q_b === eb, tag, is_narrow(c) ? "R3" : "R2", "q_b", 32'(q_b), 32'(eb));
        check(ppar_out === exp_ppar(), tag, (c == 2'b10) ? "R9" : "R8", "ppar_out",
              32'(ppar_out), 32'(exp_ppar()));
        check(err_n === m_errn, tag, (c == 2'b01) ? "R10" : ((c == 2'b10) ? "R9" : "R7"),
              "err_n", 32'(err_n), 32'(m_errn));
    endtask

    // random word with good (bad=0) or bad (bad=1) parity for the given mode
    task automatic rand_step(input logic [1:0] c, input logic [1:0] cs, input bit bad,
                             input string tag);
        logic [24:0] dv;
        dv = 25'($urandom);
        step(c, cs, dv, checked_xor(dv, c) ^ bad, 1'($urandom), 1'b1, tag);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset clears everything
        for (int k = 0; k < 3; k++) step(2'b00, 2'b00, 25'($urandom), 1'b1, 1'b0, 1'b0, "R1");
        check(q_a == '0 && q_b == '0 && err_n == 1'b1, "R1", "R1", "reset_state",
              32'({q_a, err_n}), 32'(1));

        // R2/R7/R8: wide topology, mixed good and bad words
        for (int k = 0; k < 30; k++) rand_step(2'b00, 2'($urandom_range(0, 2)), 1'($urandom), "R2");
        // R7: two consecutive bad words then a good one
        rand_step(2'b00, 2'b00, 1'b1, "R7");
        rand_step(2'b00, 2'b00, 1'b1, "R7");
        rand_step(2'b00, 2'b00, 1'b0, "R7");
        rand_step(2'b00, 2'b00, 1'b0, "R7");

        // R6: only control bits differ; parity computed over checked bits alone
        for (int k = 0; k < 10; k++) begin
            logic [24:0] dv;
            dv = {3'($urandom), 22'h15a5a5};
            step(2'b00, 2'b00, dv, checked_xor(dv, 2'b00), 1'b0, 1'b1, "R6");
        end
        for (int k = 0; k < 10; k++) begin
            logic [24:0] dv;
            dv = {11'($urandom), 3'($urandom), 11'h2b3};
            step(2'b10, 2'b01, dv, 1'b0, checked_xor(dv, 2'b10), 1'b1, "R6");
        end

        // R4: cfg 11 is the wide topology
        for (int k = 0; k < 12; k++) rand_step(2'b11, 2'b10, 1'($urandom), "R4");

        // R3/R10: narrow leading device never reports
        for (int k = 0; k < 20; k++) rand_step(2'b01, 2'b00, 1'($urandom), "R10");

        // R9: narrow trailing device folds in ppar_in
        for (int k = 0; k < 24; k++) rand_step(2'b10, 2'($urandom_range(0, 2)), 1'($urandom), "R9");

        // R5/R11: deselect collides with a pending bad word
        for (int k = 0; k < 16; k++) begin
            rand_step(2'b00, 2'b00, 1'b1, "R11");
            rand_step(2'b00, 2'b11, 1'($urandom), "R5");
            rand_step(2'b00, 2'b11, 1'($urandom), "R5");
        end
        for (int k = 0; k < 12; k++) begin
            rand_step(2'b10, 2'b01, 1'b1, "R11");
            rand_step(2'b10, 2'b11, 1'b1, "R5");
        end

        // R1: reset in the middle of traffic
        rand_step(2'b00, 2'b00, 1'b1, "R1");
        step(2'b00, 2'b00, 25'h1ffffff, 1'b0, 1'b0, 1'b0, "R1");
        rand_step(2'b00, 2'b11, 1'b1, "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule